// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous 1,024-row DRAM alive. Out of reset it waits a programmable settling pause. It then runs a burst of wake-up refresh cycles and raises an init-done flag. From then on it schedules one CAS-before-RAS refresh per distributed interval, so that every row is visited within the retention period. Each refresh drives both CAS lanes low before RAS falls, so the address pins and data bus play no part in the cycle.

The block shares the strobes with an access controller through a request/grant pair. It raises `ref_req` when it needs the bus and waits for `ref_gnt` before it touches a strobe. It keeps `ref_req` high until its cycle has ended. When the controller holds off, missed intervals are counted as debt. Once the debt reaches its limit, `ref_urgent` tells the controller to grant before it opens another page. One more missed interval at the limit means retention can no longer be trusted: `init_done` drops and the wake-up burst is repeated.

A low-power request, honoured only after initialization, parks the DRAM in self refresh. The block enters with a CBR cycle and holds RAS low for at least the minimum self-refresh time. On exit it precharges and then resumes distributed refresh with a fresh interval and no catch-up burst.

Top module: `dram_refresh_seq`

## Requirements
- R1: Out of reset `ras_n` and every `cas_n` lane are high and `ref_req`, `init_done`, `lp_ack` are low; `ref_req` first rises after exactly PAUSE_CYC clock edges following reset release.
- R2: In every refresh cycle all `cas_n` lanes carry the same value, and they are low for exactly CSR_CYC cycles with `ras_n` high immediately before `ras_n` falls.
- R3: In a refresh cycle other than self refresh, `ras_n` stays low for RAS_CYC cycles and CAS stays low for the first CHR_CYC of them. Before CAS falls again, `ras_n` has been high for more than RP_CYC cycles.
- R4: The first wake-up burst contains exactly WAKE_CNT RAS pulses, and `init_done` rises at its end.
- R5: No strobe moves unless `ref_req` is high; while `ref_gnt` is low and a cycle is pending, `ref_req` stays high and the strobes stay idle.
- R6: With the grant held, consecutive distributed refreshes start exactly REF_INTERVAL cycles apart.
- R7: Intervals missed while the grant is withheld accumulate. After the grant, that many refresh cycles run back to back before `ref_req` drops.
- R8: `ref_urgent` is high exactly while the missed-interval count equals DEBT_MAX.
- R9: An interval that elapses while the count is at DEBT_MAX drops `init_done` and clears `ref_urgent` at the same edge, exactly REF_INTERVAL cycles after `ref_urgent` rose. The next grant then runs a full WAKE_CNT-pulse burst, after which `init_done` rises again.
- R10: A low-power request after init is served with a CBR entry. `lp_ack` is high while `ras_n` and both CAS lanes are held low. RAS stays low for max(SELF_MIN_CYC, the request length) cycles, rising one cycle after the request drops.
- R11: On leaving self refresh, `ras_n` stays high for RP_CYC precharge cycles. The next refresh starts a full interval later (RAS high for RP_CYC+REF_INTERVAL+1+CSR_CYC cycles), with no catch-up burst, and `init_done` stays high throughout.
- R12: A low-power request before `init_done` is ignored: `lp_ack` stays low and the wake-up burst completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Bus grant from the access controller |
| lp_req | input | 1 | Request to enter and stay in self refresh |
| ref_req | output | 1 | Bus request; held through an owned cycle |
| ref_urgent | output | 1 | Refresh debt at its limit; grant before the next page access |
| init_done | output | 1 | Wake-up sequence complete, accesses allowed |
| lp_ack | output | 1 | DRAM is held in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes, one per byte lane, active low |

## Verification
The bench runs the sequencer with the grant held permanently. This separates the wake-up burst length and the steady refresh spacing from any effect of arbitration. It then withholds the grant for one and for two intervals, which shows whether debt is counted per interval and then repaid cycle by cycle. It withholds the grant until debt overflows, which tells the urgent warning apart from the loss of retention and the repeated burst. Self refresh is requested both shorter and much longer than the minimum, separating the minimum-hold rule from request tracking; the gap to the next refresh shows that no catch-up burst follows.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_CASSET,
        ST_RASLOW,
        ST_PRECH,
        ST_SELF,
        ST_SELFEXIT
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_NORMAL,
        MD_WAKE,
        MD_SELF
    } seq_mode_e;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [TW-1:0] ivl;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = 1'b0;
        if (!run) begin
            tmr_d.ivl = '0;
        end else if (tmr_q.ivl == TW'(INTERVAL - 1)) begin
            tmr_d.ivl = '0;
            tick      = 1'b1;
        end else begin
            tmr_d.ivl = tmr_q.ivl + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
    parameter int DEBT_MAX = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic done,
    output logic pending,
    output logic urgent,
    output logic lost
);
    localparam int DW = $clog2(DEBT_MAX + 1);

    typedef struct packed {
        logic [DW-1:0] debt;
    } debt_t;

    debt_t dbt_d, dbt_q;

    always_comb begin
        dbt_d = dbt_q;
        lost  = 1'b0;
        if (clear) begin
            dbt_d.debt = '0;
        end else if (tick && dbt_q.debt == DW'(DEBT_MAX)) begin
            dbt_d.debt = '0;
            lost       = 1'b1;
        end else if (tick && !done) begin
            dbt_d.debt = dbt_q.debt + 1'b1;
        end else if (!tick && done && dbt_q.debt != '0) begin
            dbt_d.debt = dbt_q.debt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbt_q <= '0;
        else        dbt_q <= dbt_d;
    end

    assign pending = (dbt_q.debt != '0);
    assign urgent  = (dbt_q.debt == DW'(DEBT_MAX));
endmodule

// File: rtl/refresh_cycle_fsm.sv
module refresh_cycle_fsm
    import dram_refresh_pkg::*;
#(
    parameter int PAUSE_CYC    = 10000,
    parameter int WAKE_CNT     = 8,
    parameter int CSR_CYC      = 1,
    parameter int CHR_CYC      = 1,
    parameter int RAS_CYC      = 3,
    parameter int RP_CYC       = 2,
    parameter int SELF_MIN_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic lp_req,
    input  logic debt_pending,
    input  logic lost,
    output logic ref_req,
    output logic init_done,
    output logic lp_ack,
    output logic ras_n,
    output logic cas_low,
    output logic cbr_done,
    output logic acct_en
);
    localparam int M1 = (PAUSE_CYC > SELF_MIN_CYC) ? PAUSE_CYC : SELF_MIN_CYC;
    localparam int M2 = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
    localparam int M3 = (M2 > CSR_CYC) ? M2 : CSR_CYC;
    localparam int MAXC = (M1 > M3) ? M1 : M3;
    localparam int CW = $clog2(MAXC + 1);
    localparam int WW = $clog2(WAKE_CNT + 1);

    typedef struct packed {
        seq_state_e    st;
        seq_mode_e     mode;
        logic [CW-1:0] cnt;
        logic [WW-1:0] wcnt;
        logic          wake_pend;
        logic          ready;
    } fsm_t;

    fsm_t s_d, s_q;
    logic want;

    always_comb begin
        s_d      = s_q;
        cbr_done = 1'b0;
        want     = s_q.wake_pend || (lp_req && s_q.ready) || debt_pending;
        unique case (s_q.st)
            ST_PAUSE: begin
                if (s_q.cnt == CW'(PAUSE_CYC - 1)) begin
                    s_d.st        = ST_IDLE;
                    s_d.cnt       = '0;
                    s_d.wake_pend = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (want && ref_gnt) begin
                    s_d.st   = ST_CASSET;
                    s_d.cnt  = '0;
                    s_d.wcnt = '0;
                    if (s_q.wake_pend)               s_d.mode = MD_WAKE;
                    else if (lp_req && s_q.ready)    s_d.mode = MD_SELF;
                    else                             s_d.mode = MD_NORMAL;
                end
            end
            ST_CASSET: begin
                if (s_q.cnt == CW'(CSR_CYC - 1)) begin
                    s_d.st  = (s_q.mode == MD_SELF) ? ST_SELF : ST_RASLOW;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RASLOW: begin
                if (s_q.cnt == CW'(RAS_CYC - 1)) begin
                    s_d.st  = ST_PRECH;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_PRECH: begin
                if (s_q.cnt == CW'(RP_CYC - 1)) begin
                    s_d.cnt = '0;
                    if (s_q.mode == MD_WAKE) begin
                        if (s_q.wcnt == WW'(WAKE_CNT - 1)) begin
                            s_d.st        = ST_IDLE;
                            s_d.mode      = MD_NORMAL;
                            s_d.ready     = 1'b1;
                            s_d.wake_pend = 1'b0;
                        end else begin
                            s_d.wcnt = s_q.wcnt + 1'b1;
                            s_d.st   = ST_CASSET;
                        end
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.mode = MD_NORMAL;
                        cbr_done = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SELF: begin
                if (s_q.cnt == CW'(SELF_MIN_CYC - 1)) begin
                    if (!lp_req) begin
                        s_d.st  = ST_SELFEXIT;
                        s_d.cnt = '0;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SELFEXIT: begin
                if (s_q.cnt == CW'(RP_CYC - 1)) begin
                    s_d.st   = ST_IDLE;
                    s_d.mode = MD_NORMAL;
                    s_d.cnt  = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
        if (lost) begin
            s_d.wake_pend = 1'b1;
            s_d.ready     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st        <= ST_PAUSE;
            s_q.mode      <= MD_NORMAL;
            s_q.cnt       <= '0;
            s_q.wcnt      <= '0;
            s_q.wake_pend <= 1'b0;
            s_q.ready     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ras_n     = !(s_q.st == ST_RASLOW || s_q.st == ST_SELF);
    assign cas_low   = (s_q.st == ST_CASSET) || (s_q.st == ST_SELF) ||
                       (s_q.st == ST_RASLOW && s_q.cnt < CW'(CHR_CYC));
    assign ref_req   = (s_q.st != ST_PAUSE && s_q.st != ST_IDLE) ||
                       (s_q.st == ST_IDLE && want);
    assign init_done = s_q.ready;
    assign lp_ack    = (s_q.st == ST_SELF);
    assign acct_en   = s_q.ready && (s_q.mode != MD_SELF);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int PAUSE_CYC    = 10000,
    parameter int WAKE_CNT     = 8,
    parameter int REF_INTERVAL = 780,
    parameter int CSR_CYC      = 1,
    parameter int CHR_CYC      = 1,
    parameter int RAS_CYC      = 3,
    parameter int RP_CYC       = 2,
    parameter int SELF_MIN_CYC = 5000,
    parameter int DEBT_MAX     = 3,
    parameter int CAS_LANES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_gnt,
    input  logic                 lp_req,
    output logic                 ref_req,
    output logic                 ref_urgent,
    output logic                 init_done,
    output logic                 lp_ack,
    output logic                 ras_n,
    output logic [CAS_LANES-1:0] cas_n
);
    logic tick, acct_en, cbr_done, debt_pending, lost, cas_low;

    refresh_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (acct_en),
        .tick  (tick)
    );

    refresh_debt_counter #(.DEBT_MAX(DEBT_MAX)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!acct_en),
        .tick    (tick),
        .done    (cbr_done),
        .pending (debt_pending),
        .urgent  (ref_urgent),
        .lost    (lost)
    );

    refresh_cycle_fsm #(
        .PAUSE_CYC    (PAUSE_CYC),
        .WAKE_CNT     (WAKE_CNT),
        .CSR_CYC      (CSR_CYC),
        .CHR_CYC      (CHR_CYC),
        .RAS_CYC      (RAS_CYC),
        .RP_CYC       (RP_CYC),
        .SELF_MIN_CYC (SELF_MIN_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_gnt      (ref_gnt),
        .lp_req       (lp_req),
        .debt_pending (debt_pending),
        .lost         (lost),
        .ref_req      (ref_req),
        .init_done    (init_done),
        .lp_ack       (lp_ack),
        .ras_n        (ras_n),
        .cas_low      (cas_low),
        .cbr_done     (cbr_done),
        .acct_en      (acct_en)
    );

    for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
        assign cas_n[g] = !cas_low;
    end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
    parameter int CAS_LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ref_req,
    input logic                 ref_urgent,
    input logic                 init_done,
    input logic                 lp_ack,
    input logic                 ras_n,
    input logic [CAS_LANES-1:0] cas_n
);
    p_lanes_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n == '0) || (cas_n == '1));

    p_cas_leads_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == '0));

    p_bus_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || cas_n != '1) |-> ref_req);

    p_urgent_requests_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    p_rewake_after_urgent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> $past(ref_urgent));

    p_self_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lp_ack |-> (!ras_n && cas_n == '0));

    p_self_needs_init_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lp_ack |-> init_done);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.CAS_LANES(CAS_LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .init_done  (init_done),
    .lp_ack     (lp_ack),
    .ras_n      (ras_n),
    .cas_n      (cas_n)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
    localparam int PAUSE = 50;
    localparam int WAKE  = 8;
    localparam int IVL   = 40;
    localparam int CSR   = 2;
    localparam int CHR   = 3;
    localparam int RASC  = 5;
    localparam int RP    = 3;
    localparam int SMIN  = 20;
    localparam int DMAX  = 3;
    localparam int LIMIT = 20000;

    logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0, lp_req = 1'b0;
    logic ref_req, ref_urgent, init_done, lp_ack, ras_n;
    logic [1:0] cas_n;

    int checks = 0, failures = 0;
    int mon_checks = 0, mon_fails = 0;
    int cyc = 0, n_falls = 0, t_fall = 0, last_low = 0, last_hi = 0;
    int low_run = 0, hi_run = 1000, cas_run = 0, cas_hold = 0, early_ack = 0;
    logic self_seen = 1'b0, pr_ras = 1'b1;
    logic [1:0] pr_cas = 2'b11;

    always #10 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .REF_INTERVAL(IVL), .CSR_CYC(CSR),
        .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RP), .SELF_MIN_CYC(SMIN),
        .DEBT_MAX(DMAX), .CAS_LANES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .lp_req(lp_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .init_done(init_done),
        .lp_ack(lp_ack), .ras_n(ras_n), .cas_n(cas_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        mon_checks++;
        if (!ok) begin
            mon_fails++;
            $display("FAIL %s actual=%0d expected=%0d (monitor)", req, act, exp);
        end
    endtask

    // strobe monitor: measures every pulse against R2/R3
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (lp_ack && !init_done) early_ack++;
            if (cas_n != 2'b00 && cas_n != 2'b11) mchk(0, "R2 lanes", cas_n, 0);
            if (pr_ras && !ras_n) begin
                mchk(cas_run == CSR, "R2 cas setup", cas_run, CSR);
                n_falls++;
                t_fall = cyc;
                last_hi = hi_run;
                low_run = 1;
                cas_hold = (cas_n == 2'b00) ? 1 : 0;
                self_seen = lp_ack;
            end else if (!ras_n) begin
                low_run++;
                if (cas_n == 2'b00) cas_hold++;
                if (lp_ack) self_seen = 1'b1;
            end else if (!pr_ras && ras_n) begin
                last_low = low_run;
                hi_run = 1;
                if (!self_seen) begin
                    mchk(low_run == RASC, "R3 ras width", low_run, RASC);
                    mchk(cas_hold == CHR, "R3 cas hold", cas_hold, CHR);
                end
            end else begin
                hi_run++;
            end
            if (ras_n && cas_n == 2'b00) begin
                if (pr_cas == 2'b11) mchk(hi_run > RP, "R3 precharge", hi_run, RP + 1);
                cas_run++;
            end else begin
                cas_run = 0;
            end
            pr_ras = ras_n;
            pr_cas = cas_n;
        end
    end

    task automatic finish_run();
        checks   += mon_checks;
        failures += mon_fails;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > LIMIT) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, LIMIT);
                finish_run();
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_fall();
        int nf = n_falls;
        while (n_falls == nf) step();
    endtask

    initial begin
        int n, nf, t0, tu, bad;
        lp_req = 1'b1;                       // R12: request present during init
        repeat (3) step();
        chk(ras_n && cas_n == 2'b11 && !ref_req && !init_done && !lp_ack,
            "R1 reset state", {ras_n, cas_n, ref_req, init_done, lp_ack}, 6'b111000);
        rst_n = 1'b1;
        n = 0;
        while (!ref_req) begin step(); n++; end
        chk(n == PAUSE, "R1 pause", n, PAUSE);

        bad = 0;
        repeat (10) begin
            step();
            if (!(ras_n && cas_n == 2'b11 && ref_req)) bad++;
        end
        chk(bad == 0, "R5 no strobe without grant", bad, 0);

        ref_gnt = 1'b1;
        while (!init_done) step();
        lp_req = 1'b0;
        chk(n_falls == WAKE, "R4 wake burst", n_falls, WAKE);
        chk(early_ack == 0, "R12 lp ignored before init", early_ack, 0);
        chk(n_falls == WAKE, "R12 burst unchanged", n_falls, WAKE);

        wait_fall();
        for (int i = 0; i < 3; i++) begin
            t0 = t_fall;
            wait_fall();
            chk(t_fall - t0 == IVL, "R6 interval", t_fall - t0, IVL);
        end

        for (int k = 1; k <= 2; k++) begin
            wait_fall();
            ref_gnt = 1'b0;
            repeat (k * IVL) step();
            chk(ref_req && ras_n && cas_n == 2'b11, "R5 held off", {ref_req, ras_n}, 2'b11);
            chk(!ref_urgent, "R8 below limit", ref_urgent, 0);
            nf = n_falls;
            ref_gnt = 1'b1;
            while (ref_req) step();
            chk(n_falls - nf == k, "R7 debt repaid", n_falls - nf, k);
        end

        wait_fall();
        t0 = cyc;
        ref_gnt = 1'b0;
        while (!ref_urgent) step();
        tu = cyc;
        chk(tu - t0 >= 2 * IVL, "R8 urgent after limit", tu - t0, 2 * IVL);
        chk(init_done, "R8 still ready", init_done, 1);
        while (init_done) step();
        chk(cyc - tu == IVL, "R9 loss one interval later", cyc - tu, IVL);
        chk(!ref_urgent && ref_req, "R9 urgent cleared, request up", {ref_urgent, ref_req}, 2'b01);
        nf = n_falls;
        ref_gnt = 1'b1;
        while (!init_done) step();
        chk(n_falls - nf == WAKE, "R9 repeated burst", n_falls - nf, WAKE);

        // short self-refresh request
        while (ref_req) step();
        lp_req = 1'b1;
        while (!lp_ack) step();
        chk(!ras_n && cas_n == 2'b00, "R10 entry strobes", {ras_n, cas_n}, 0);
        lp_req = 1'b0;
        while (!ras_n) step();
        chk(last_low == SMIN, "R10 minimum hold", last_low, SMIN);
        wait_fall();
        chk(last_hi == RP + IVL + 1 + CSR, "R11 no catch-up", last_hi, RP + IVL + 1 + CSR);
        chk(init_done, "R11 init kept", init_done, 1);

        // long self-refresh request spanning several intervals
        while (ref_req) step();
        lp_req = 1'b1;
        while (!lp_ack) step();
        bad = 0;
        for (int h = 0; h < 3 * IVL; h++) begin
            step();
            if (!lp_ack) bad++;
        end
        lp_req = 1'b0;
        chk(bad == 0, "R10 held while requested", bad, 0);
        while (!ras_n) step();
        chk(last_low == 3 * IVL + 1, "R10 tracks request", last_low, 3 * IVL + 1);
        chk(init_done, "R11 no loss in self refresh", init_done, 1);
        wait_fall();
        chk(last_hi == RP + IVL + 1 + CSR, "R11 exit gap", last_hi, RP + IVL + 1 + CSR);

        repeat (5) step();
        finish_run();
    end
endmodule